// File: doc/BRIEF.md
# Wiper Position Store Controller

This block decides when the 5-bit position of a push-button potentiometer is saved to a nonvolatile cell, and when the saved position comes back. After each power-up it waits for its input synchronizer to settle. It then samples the store-enable pin once and fixes the store mode until the next reset: a low pin selects automatic store and a high pin selects manual store. In the same step it hands the recalled position to the wiper counter. A cell that has never been written recalls mid-scale.

In automatic mode, every button event restarts an idle countdown. When the countdown ends, the block writes the current position, but only if that position differs from the stored one. In manual mode, the pin acts as a store button. Holding it low locks the wiper buttons out. Releasing it after a long enough hold triggers one store. During a write cycle, the block flags busy and tells the wiper logic to ignore its buttons.

The nonvolatile cell is modelled as a data register with a valid bit and a busy interval. Its own reset stands for a factory-blank part, and the ordinary reset stands for a power cycle. The controller states are: boot settle (`ST_BOOT`), recall load (`ST_LOAD`), ready (`ST_READY`), idle countdown (`ST_QUIET`), pin held (`ST_HOLD`), write issue (`ST_STORE`) and write drain (`ST_DRAIN`).

The state transitions are:
- BOOT to LOAD after the settle count.
- LOAD to READY after one cycle.
- READY to QUIET on a button event in automatic mode.
- READY to HOLD when the pin goes low in manual mode.
- QUIET stays in QUIET on a button event, with the countdown restarted.
- QUIET to STORE when the countdown ends and the position differs from the stored value, or to READY when it is equal.
- HOLD to STORE on a qualified release, or to READY on a short one.
- STORE to DRAIN after one cycle.
- DRAIN to READY when the cell is no longer busy.

Top module: `wiper_store_ctrl`

## Requirements
- R1: While `rst_n` is low, `nv_write_req` and `busy` are 0. After reset, `recall_load` is high for exactly one cycle. If the cell is blank, `recall_pos` then shows the mid-scale code 16.
- R2: `auto_mode` equals the inverse of the synchronized `store_en_n` level sampled once after power-up, and it does not change until the next reset. In automatic mode, pulls on the pin start no write.
- R3: In automatic mode, `nv_write_req` rises exactly IDLE_CYC cycles after the clock edge that last sampled `btn_event` high. The value written is `wiper_pos` in that request cycle.
- R4: A `btn_event` during the countdown restarts it from zero, so only the last event sets the write time.
- R5: In automatic mode, no write is issued when the cell is valid and already holds the current `wiper_pos`.
- R6: One idle period gives at most one write. Without a new `btn_event`, no further write follows.
- R7: In manual mode, holding the synchronized pin low for more than DEB_CYC cycles and then releasing it issues exactly one write of `wiper_pos`. Button events alone never write in manual mode.
- R8: In manual mode, a low pulse shorter than DEB_CYC cycles issues no write.
- R9: In manual mode, `ignore_btn` is high whenever the pin, seen through the two-stage synchronizer, is low.
- R10: Each write keeps `busy` high for WRITE_CYC+2 cycles: the request cycle, WRITE_CYC cell-busy cycles and one release cycle. `ignore_btn` is high whenever `busy` is high.
- R11: `nv_write_req` is a single-cycle pulse.
- R12: After a power cycle (a `rst_n` pulse) with a written cell, `recall_pos` equals the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset of the controller |
| cell_rst_n | input | 1 | Active-low blank state of the nonvolatile cell model |
| store_en_n | input | 1 | Raw store-enable pin, mode select at power-up, store button in manual mode |
| btn_event | input | 1 | One-cycle pulse for any wiper button activity |
| wiper_pos | input | 5 | Current wiper counter value |
| recall_load | output | 1 | One-cycle strobe to load `recall_pos` into the wiper counter |
| recall_pos | output | 5 | Recalled position, stored value or mid-scale |
| nv_write_req | output | 1 | Write request pulse to the nonvolatile cell |
| busy | output | 1 | Write cycle in progress |
| ignore_btn | output | 1 | Wiper must ignore its buttons |
| auto_mode | output | 1 | 1 for automatic store, 0 for manual store |

## Verification
The bench measures the distance from the last button event to the write request. An off-by-one countdown, or one that does not restart on a new event, shows up as a wrong latency or a second write. It checks that an equal position produces no write and that a finished idle period is not followed by another one; a design that skips the comparison or re-arms itself would wear the cell with extra writes. In manual mode it applies pin pulses well below and well above the qualification length, and it checks that automatic mode ignores the pin. A design that latched the mode continuously, or that triggered on the falling edge, would store at the wrong times. Power cycles with a blank cell and with a written cell catch a wrong mid-scale default or a stale recall.

// File: rtl/wstore_pkg.sv
package wstore_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LOAD,
        ST_READY,
        ST_QUIET,
        ST_HOLD,
        ST_STORE,
        ST_DRAIN
    } wstore_state_t;

    localparam int SETTLE_CYC = 3;

endpackage

// File: rtl/wstore_sync.sv
module wstore_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wstore_cell.sv
module wstore_cell #(
    parameter int W         = 5,
    parameter int WRITE_CYC = 20000
) (
    input  logic         clk,
    input  logic         cell_rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] data_q,
    output logic         valid_q,
    output logic         busy_q
);
    localparam int BW = $clog2(WRITE_CYC + 1);

    logic [BW-1:0] left_q;

    always_ff @(posedge clk or negedge cell_rst_n) begin
        if (!cell_rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            busy_q  <= 1'b0;
            left_q  <= '0;
        end else if (wr_req) begin
            data_q  <= wr_data;
            valid_q <= 1'b1;
            busy_q  <= 1'b1;
            left_q  <= BW'(WRITE_CYC - 1);
        end else if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - BW'(1);
        end
    end
endmodule

// File: rtl/wstore_fsm.sv
module wstore_fsm
    import wstore_pkg::*;
#(
    parameter int W        = 5,
    parameter int DEB_CYC  = 15000,
    parameter int IDLE_CYC = 2000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_lvl,
    input  logic         btn_event,
    input  logic [W-1:0] wiper_pos,
    input  logic         cell_busy,
    input  logic         cell_valid,
    input  logic [W-1:0] cell_data,
    output logic         write_req,
    output logic         busy,
    output logic         ignore_btn,
    output logic         recall_load,
    output logic         auto_mode
);
    localparam int CMAX = (IDLE_CYC > DEB_CYC) ? IDLE_CYC : DEB_CYC;
    localparam int CW   = $clog2(CMAX + SETTLE_CYC + 1);

    wstore_state_t state_q;
    logic [CW-1:0] cnt_q;
    logic          mode_q;
    logic          same_pos;

    assign same_pos = cell_valid && (wiper_pos == cell_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    if (cnt_q == CW'(SETTLE_CYC - 1)) begin
                        mode_q  <= ~pin_lvl;
                        cnt_q   <= '0;
                        state_q <= ST_LOAD;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_LOAD: state_q <= ST_READY;
                ST_READY: begin
                    cnt_q <= '0;
                    if (mode_q && btn_event)      state_q <= ST_QUIET;
                    else if (!mode_q && !pin_lvl) state_q <= ST_HOLD;
                end
                ST_QUIET: begin
                    if (btn_event) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CW'(IDLE_CYC - 1)) begin
                        cnt_q   <= '0;
                        state_q <= same_pos ? ST_READY : ST_STORE;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_HOLD: begin
                    if (pin_lvl) begin
                        cnt_q   <= '0;
                        state_q <= (cnt_q >= CW'(DEB_CYC)) ? ST_STORE : ST_READY;
                    end else if (cnt_q < CW'(DEB_CYC)) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_STORE: state_q <= ST_DRAIN;
                ST_DRAIN: if (!cell_busy) state_q <= ST_READY;
                default:  state_q <= ST_BOOT;
            endcase
        end
    end

    always_comb begin
        write_req   = (state_q == ST_STORE);
        busy        = (state_q == ST_STORE) || (state_q == ST_DRAIN);
        recall_load = (state_q == ST_LOAD);
        ignore_btn  = (state_q == ST_BOOT) || (state_q == ST_LOAD) || busy ||
                      (!mode_q && !pin_lvl);
        auto_mode   = mode_q;
    end
endmodule

// File: rtl/wiper_store_ctrl.sv
module wiper_store_ctrl #(
    parameter int W           = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 15000,
    parameter int IDLE_CYC    = 2000000,
    parameter int WRITE_CYC   = 20000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cell_rst_n,
    input  logic         store_en_n,
    input  logic         btn_event,
    input  logic [W-1:0] wiper_pos,
    output logic         recall_load,
    output logic [W-1:0] recall_pos,
    output logic         nv_write_req,
    output logic         busy,
    output logic         ignore_btn,
    output logic         auto_mode
);
    localparam logic [W-1:0] MID_CODE = W'(1 << (W - 1));

    logic         pin_s;
    logic [W-1:0] cell_data;
    logic         cell_valid;
    logic         cell_busy;

    wstore_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (store_en_n),
        .dout (pin_s)
    );

    wstore_fsm #(.W(W), .DEB_CYC(DEB_CYC), .IDLE_CYC(IDLE_CYC)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_s),
        .btn_event  (btn_event),
        .wiper_pos  (wiper_pos),
        .cell_busy  (cell_busy),
        .cell_valid (cell_valid),
        .cell_data  (cell_data),
        .write_req  (nv_write_req),
        .busy       (busy),
        .ignore_btn (ignore_btn),
        .recall_load(recall_load),
        .auto_mode  (auto_mode)
    );

    wstore_cell #(.W(W), .WRITE_CYC(WRITE_CYC)) i_cell (
        .clk       (clk),
        .cell_rst_n(cell_rst_n),
        .wr_req    (nv_write_req),
        .wr_data   (wiper_pos),
        .data_q    (cell_data),
        .valid_q   (cell_valid),
        .busy_q    (cell_busy)
    );

    assign recall_pos = cell_valid ? cell_data : MID_CODE;
endmodule

// File: rtl/wstore_chk.sv
module wstore_chk (
    input logic clk,
    input logic rst_n,
    input logic store_en_n,
    input logic nv_write_req,
    input logic busy,
    input logic ignore_btn,
    input logic recall_load,
    input logic auto_mode
);
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nv_write_req |=> !nv_write_req);

    a_r10_req_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        nv_write_req |=> busy);

    a_r10_busy_locks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ignore_btn);

    a_r1_recall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        recall_load |=> !recall_load);

    a_r2_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_load |-> $stable(auto_mode));

    a_r9_manual_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && !$past(store_en_n, 2)) |-> ignore_btn);
endmodule

bind wiper_store_ctrl wstore_chk i_wstore_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_en_n  (store_en_n),
    .nv_write_req(nv_write_req),
    .busy        (busy),
    .ignore_btn  (ignore_btn),
    .recall_load (recall_load),
    .auto_mode   (auto_mode)
);

// File: tb/test_wiper_store_ctrl.sv
`timescale 1ns/1ps
module test_wiper_store_ctrl;
    localparam int W     = 5;
    localparam int DEB   = 8;
    localparam int IDLE  = 200;
    localparam int WRC   = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cell_rst_n = 1'b0;
    logic         store_en_n = 1'b0;
    logic         btn_event = 1'b0;
    logic [W-1:0] wiper_pos = '0;
    logic         recall_load;
    logic [W-1:0] recall_pos;
    logic         nv_write_req;
    logic         busy;
    logic         ignore_btn;
    logic         auto_mode;

    int checks = 0;
    int fails = 0;
    int edge_cnt = 0;
    int ev_edge = 0;
    int wr_count = 0;
    int wr_edge = 0;
    int last_wr_pos = 0;
    int busy_run = 0;
    int last_busy_len = 0;
    bit done = 0;
    bit exp_valid = 0;
    int exp_val = 0;

    wiper_store_ctrl #(.W(W), .DEB_CYC(DEB), .IDLE_CYC(IDLE), .WRITE_CYC(WRC))
    i_wiper_store_ctrl (
        .clk(clk), .rst_n(rst_n), .cell_rst_n(cell_rst_n), .store_en_n(store_en_n),
        .btn_event(btn_event), .wiper_pos(wiper_pos), .recall_load(recall_load),
        .recall_pos(recall_pos), .nv_write_req(nv_write_req), .busy(busy),
        .ignore_btn(ignore_btn), .auto_mode(auto_mode)
    );

    always #2 clk = ~clk;

    always @(posedge clk) edge_cnt++;

    always @(negedge clk) begin
        if (rst_n && nv_write_req) begin
            wr_count++;
            wr_edge = edge_cnt;
            last_wr_pos = int'(wiper_pos);
        end
        if (busy) busy_run++;
        else if (busy_run != 0) begin
            last_busy_len = busy_run;
            busy_run = 0;
        end
    end

    function automatic int exp_recall(bit v, int val);
        return v ? val : (1 << (W - 1));
    endfunction

    function automatic bit exp_write(bit v, int stored, int pos);
        return !v || (stored != pos);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up(bit pin, bit blank);
        int waited;
        @(negedge clk);
        rst_n = 1'b0;
        if (blank) cell_rst_n = 1'b0;
        store_en_n = pin;
        btn_event = 1'b0;
        cycles(3);
        chk(nv_write_req == 1'b0 && busy == 1'b0, "R1 reset quiet", int'(busy), 0);
        rst_n = 1'b1;
        cell_rst_n = 1'b1;
        if (blank) exp_valid = 0;
        waited = 0;
        while (!recall_load && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(recall_load == 1'b1, "R1 recall strobe", int'(recall_load), 1);
        chk(int'(recall_pos) == exp_recall(exp_valid, exp_val), "R1/R12 recall value",
            int'(recall_pos), exp_recall(exp_valid, exp_val));
        wiper_pos = recall_pos;
        @(negedge clk);
        chk(recall_load == 1'b0, "R1 recall one cycle", int'(recall_load), 0);
        chk(auto_mode == !pin, "R2 mode select", int'(auto_mode), int'(!pin));
    endtask

    task automatic pulse_evt(int pos);
        wiper_pos = W'(pos);
        btn_event = 1'b1;
        ev_edge = edge_cnt + 1;
        @(negedge clk);
        btn_event = 1'b0;
    endtask

    task automatic pull_pin(int len);
        store_en_n = 1'b0;
        cycles(len);
        store_en_n = 1'b1;
    endtask

    task automatic note_write(int pos);
        exp_valid = 1;
        exp_val = pos;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int dummy;
        dummy = $urandom(1234);

        // blank cell, automatic mode
        power_up(1'b0, 1'b1);

        // R3: write after idle period with exact latency
        base = wr_count;
        pulse_evt(20);
        cycles(IDLE + WRC + 10);
        chk(wr_count == base + 1, "R3 auto write count", wr_count - base, 1);
        chk(wr_edge - ev_edge == IDLE, "R3 auto write latency", wr_edge - ev_edge, IDLE);
        chk(last_wr_pos == 20, "R3 written value", last_wr_pos, 20);
        chk(last_busy_len == WRC + 2, "R10 busy length", last_busy_len, WRC + 2);
        note_write(20);

        // R4: restart on new event; R6 single write
        base = wr_count;
        pulse_evt(12);
        cycles(IDLE / 2);
        pulse_evt(9);
        cycles(IDLE + WRC + 10);
        chk(wr_count == base + 1, "R4 restart single write", wr_count - base, 1);
        chk(wr_edge - ev_edge == IDLE, "R4 latency from last event", wr_edge - ev_edge, IDLE);
        chk(last_wr_pos == 9, "R4 written value", last_wr_pos, 9);
        note_write(9);
        base = wr_count;
        cycles(2 * IDLE);
        chk(wr_count == base, "R6 no rewrite without activity", wr_count - base, 0);

        // R5: equal position skipped
        pulse_evt(9);
        cycles(IDLE + 20);
        chk(wr_count == base, "R5 equal position skipped", wr_count - base, 0);

        // R2: pin pulls ignored in automatic mode
        pull_pin(DEB + 5);
        cycles(60);
        chk(wr_count == base, "R2 pin ignored in auto", wr_count - base, 0);

        // random idle periods
        for (int r = 0; r < 6; r++) begin
            int n;
            int pos;
            bit expw;
            base = wr_count;
            n = int'($urandom_range(1, 4));
            pos = exp_val;
            for (int k = 0; k < n; k++) begin
                pos = (r % 3 == 0) ? exp_val : int'($urandom_range(0, 31));
                pulse_evt(pos);
                if (k != n - 1) cycles(int'($urandom_range(10, IDLE - 20)));
            end
            expw = exp_write(exp_valid, exp_val, pos);
            cycles(IDLE + WRC + 10);
            chk(wr_count - base == int'(expw), "R5/R6 random write count",
                wr_count - base, int'(expw));
            if (expw) begin
                chk(last_wr_pos == pos, "R3 random value", last_wr_pos, pos);
                chk(wr_edge - ev_edge == IDLE, "R4 random latency", wr_edge - ev_edge, IDLE);
                note_write(pos);
            end
        end

        // R12: recall after power cycle, still automatic
        power_up(1'b0, 1'b0);

        // manual mode
        power_up(1'b1, 1'b0);
        base = wr_count;
        pulse_evt(5);
        cycles(IDLE + 20);
        chk(wr_count == base, "R7 buttons never write in manual", wr_count - base, 0);

        // R8 short pull, R9 lockout
        store_en_n = 1'b0;
        cycles(4);
        chk(ignore_btn == 1'b1, "R9 lockout while held", int'(ignore_btn), 1);
        cycles(DEB - 7);
        store_en_n = 1'b1;
        cycles(30);
        chk(wr_count == base, "R8 short pull no write", wr_count - base, 0);
        chk(ignore_btn == 1'b0, "R9 lockout released", int'(ignore_btn), 0);

        // R7 qualified pull
        wiper_pos = 5'd3;
        pull_pin(DEB + 5);
        cycles(10);
        chk(busy == 1'b1 && ignore_btn == 1'b1, "R10 inputs ignored during write",
            int'(ignore_btn), 1);
        cycles(60);
        chk(wr_count == base + 1, "R7 manual store count", wr_count - base, 1);
        chk(last_wr_pos == 3, "R7 manual store value", last_wr_pos, 3);
        note_write(3);

        // R12 recall of manual value
        power_up(1'b0, 1'b0);
        finish_run();
    end
endmodule